// File: doc/BRIEF.md
# Phase-Comparison Lock Qualifier

This block decides whether a phase-locked loop has settled. It watches the single-cycle edge pulses that the reference divider and the feedback divider deliver to the phase-frequency detector. Both pulses are already synchronous to a fast sampling clock. On every comparison cycle the block counts the sampling-clock ticks between the first divider edge to arrive and the second. It then grades the cycle against two runtime thresholds. Once enough back-to-back cycles fall under the tight threshold, it raises an active-high lock flag.

Lock is hysteretic. A precision select chooses whether three or five consecutive good cycles are needed to assert lock. Once lock is held, it drops only when a single cycle exceeds the looser threshold. A cycle whose error lies between the two thresholds neither grants nor removes lock. A comparison whose second edge never arrives saturates the tick counter and is treated as a gross error. With a nominal 200 MHz sampling clock (5 ns per tick), the intended thresholds are 3 ticks (15 ns) and 5 ticks (25 ns).

Top module: `pll_lock_qualifier`

## Requirements
- R1: A synchronous active-high reset forces the lock flag to 0 and discards any partial run of good cycles, so a full run is needed again after reset.
- R2: With `precisionSel` = 0, the lock flag rises after exactly three consecutive good comparisons and is still low after two.
- R3: With `precisionSel` = 1, the lock flag rises after exactly five consecutive good comparisons and is still low after four.
- R4: A comparison is good only when its error is strictly below `tightThresh`. While unlocked, a comparison whose error equals or exceeds `tightThresh` restarts the run of good cycles from zero.
- R5: While locked, a single comparison whose error is strictly above `looseThresh` clears the lock flag. An error equal to `looseThresh` keeps lock.
- R6: While locked, errors from `tightThresh` up to `looseThresh` leave the lock flag unchanged. The lock flag never changes on a cycle without a completed comparison.
- R7: The error is the number of sampling-clock ticks from the first edge to the other edge, whichever divider leads. An edge pulse in cycle k and the other in cycle k+g give error g, and pulses in the same cycle give error 0.
- R8: If the other edge does not arrive within 2^TICK_W-1 ticks of the first, the comparison ends as a gross error and, while locked, clears the lock flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast sampling clock |
| rst | input | 1 | Synchronous reset, active high |
| refEdge | input | 1 | Single-cycle pulse marking a reference-divider edge |
| fbEdge | input | 1 | Single-cycle pulse marking a feedback-divider edge |
| precisionSel | input | 1 | 0: three good cycles to lock; 1: five |
| tightThresh | input | TICK_W | Error limit, in ticks, below which a cycle counts as good |
| looseThresh | input | TICK_W | Error limit, in ticks, above which lock is lost |
| lockFlag | output | 1 | Active-high lock indication |

## Verification
Two functions can fall in the same cycle: the start of a measurement and its completion. They coincide when both divider pulses arrive together. The bench drives both edges in one sampling cycle and expects the comparison to be graded as a zero-tick error, which counts toward lock. The second coincidence is a lock grant together with the restart of the good-cycle count. It is judged by following a fresh lock with a single loose-threshold violation and a new run that needs the full count again.

// File: rtl/lock_pkg.sv
package lock_pkg;

  // Nominal thresholds at a 200 MHz sampling clock (5 ns per tick)
  localparam int DEFAULT_TIGHT_TICKS = 3;
  localparam int DEFAULT_LOOSE_TICKS = 5;

  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_MEAS = 1'b1
  } meterState_t;

  // Strobes from the sequencer to the phase meter
  typedef struct packed {
    logic start;     // first edge seen alone: load counter, latch leader
    logic step;      // measurement running, no finish this cycle
    logic evalZero;  // both edges together while idle: error is zero
    logic evalMeas;  // trailing edge arrived: error is the counter value
    logic evalSat;   // counter saturated without a trailing edge
  } meterStrobe_t;

endpackage

// File: rtl/lock_phase_meter.sv
module lock_phase_meter
  import lock_pkg::*;
#(
  parameter int TICK_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  meterStrobe_t      stb,
  input  logic              refEdge,
  input  logic              fbEdge,
  input  logic [TICK_W-1:0] tightThresh,
  input  logic [TICK_W-1:0] looseThresh,
  output logic              otherEdge,
  output logic              atSat,
  output logic              cmpValid,
  output logic              cmpGood,
  output logic              cmpBad
);

  localparam logic [TICK_W-1:0] SAT_TICKS = {TICK_W{1'b1}};

  logic [TICK_W-1:0] tickCnt;
  logic              leaderIsRef;
  logic [TICK_W-1:0] errTicks;

  always_ff @(posedge clk) begin
    if (rst) begin
      tickCnt     <= '0;
      leaderIsRef <= 1'b0;
    end else if (stb.start) begin
      tickCnt     <= {{(TICK_W-1){1'b0}}, 1'b1};
      leaderIsRef <= refEdge;
    end else if (stb.step) begin
      tickCnt <= tickCnt + 1'b1;
    end
  end

  always_comb begin
    otherEdge = leaderIsRef ? fbEdge : refEdge;
    atSat     = (tickCnt == SAT_TICKS);
    errTicks  = stb.evalZero ? '0 : tickCnt;
    cmpValid  = stb.evalZero | stb.evalMeas | stb.evalSat;
    cmpGood   = cmpValid && !stb.evalSat && (errTicks < tightThresh);
    cmpBad    = cmpValid && (stb.evalSat || (errTicks > looseThresh));
  end

endmodule

// File: rtl/lock_sequencer.sv
module lock_sequencer
  import lock_pkg::*;
#(
  parameter int LOCK_SHORT = 3,
  parameter int LOCK_LONG  = 5,
  parameter int GCNT_W     = $clog2(LOCK_LONG + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              refEdge,
  input  logic              fbEdge,
  input  logic              precisionSel,
  input  logic              otherEdge,
  input  logic              atSat,
  input  logic              cmpValid,
  input  logic              cmpGood,
  input  logic              cmpBad,
  output meterStrobe_t      stb,
  output logic              lockFlag,
  output logic [GCNT_W-1:0] goodCnt
);

  localparam logic [GCNT_W:0] NEED_SHORT = (GCNT_W+1)'(LOCK_SHORT);
  localparam logic [GCNT_W:0] NEED_LONG  = (GCNT_W+1)'(LOCK_LONG);

  meterState_t     state;
  meterState_t     nextState;
  logic [GCNT_W:0] needCnt;
  logic [GCNT_W:0] goodNext;

  // Measurement sequencing
  always_comb begin
    stb       = '0;
    nextState = state;
    unique case (state)
      ST_IDLE: begin
        if (refEdge && fbEdge) begin
          stb.evalZero = 1'b1;
        end else if (refEdge || fbEdge) begin
          stb.start = 1'b1;
          nextState = ST_MEAS;
        end
      end
      ST_MEAS: begin
        if (otherEdge) begin
          stb.evalMeas = 1'b1;
          nextState    = ST_IDLE;
        end else if (atSat) begin
          stb.evalSat = 1'b1;
          nextState   = ST_IDLE;
        end else begin
          stb.step = 1'b1;
        end
      end
      default: nextState = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) state <= ST_IDLE;
    else     state <= nextState;
  end

  // Lock qualification with hysteresis
  always_comb begin
    needCnt  = precisionSel ? NEED_LONG : NEED_SHORT;
    goodNext = {1'b0, goodCnt} + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      lockFlag <= 1'b0;
      goodCnt  <= '0;
    end else if (cmpValid) begin
      if (lockFlag) begin
        goodCnt <= '0;
        if (cmpBad) lockFlag <= 1'b0;
      end else if (cmpGood) begin
        if (goodNext >= needCnt) begin
          lockFlag <= 1'b1;
          goodCnt  <= '0;
        end else begin
          goodCnt <= goodNext[GCNT_W-1:0];
        end
      end else begin
        goodCnt <= '0;
      end
    end
  end

endmodule

// File: rtl/pll_lock_qualifier.sv
module pll_lock_qualifier
  import lock_pkg::*;
#(
  parameter int TICK_W     = 8,
  parameter int LOCK_SHORT = 3,
  parameter int LOCK_LONG  = 5
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              refEdge,
  input  logic              fbEdge,
  input  logic              precisionSel,
  input  logic [TICK_W-1:0] tightThresh,
  input  logic [TICK_W-1:0] looseThresh,
  output logic              lockFlag
);

  localparam int GCNT_W = $clog2(LOCK_LONG + 1);

  meterStrobe_t      meterStb;
  logic              otherEdge;
  logic              atSat;
  logic              cmpValid;
  logic              cmpGood;
  logic              cmpBad;
  logic [GCNT_W-1:0] goodCnt;

  lock_phase_meter #(.TICK_W(TICK_W)) meter (
    .clk(clk), .rst(rst), .stb(meterStb),
    .refEdge(refEdge), .fbEdge(fbEdge),
    .tightThresh(tightThresh), .looseThresh(looseThresh),
    .otherEdge(otherEdge), .atSat(atSat),
    .cmpValid(cmpValid), .cmpGood(cmpGood), .cmpBad(cmpBad)
  );

  lock_sequencer #(
    .LOCK_SHORT(LOCK_SHORT), .LOCK_LONG(LOCK_LONG), .GCNT_W(GCNT_W)
  ) seq (
    .clk(clk), .rst(rst), .refEdge(refEdge), .fbEdge(fbEdge),
    .precisionSel(precisionSel), .otherEdge(otherEdge), .atSat(atSat),
    .cmpValid(cmpValid), .cmpGood(cmpGood), .cmpBad(cmpBad),
    .stb(meterStb), .lockFlag(lockFlag), .goodCnt(goodCnt)
  );

endmodule

// File: rtl/lock_checker.sv
module lock_checker #(
  parameter int LOCK_LONG = 5,
  parameter int GCNT_W    = $clog2(LOCK_LONG + 1)
) (
  input logic              clk,
  input logic              rst,
  input logic              lockFlag,
  input logic              cmpValid,
  input logic              cmpGood,
  input logic              cmpBad,
  input logic              satEval,
  input logic [GCNT_W-1:0] goodCnt
);

  AST_RESET_CLEARS: assert property (@(posedge clk)
    rst |=> (!lockFlag && goodCnt == '0));  // R1

  AST_RISE_AFTER_GOOD: assert property (@(posedge clk) disable iff (rst)
    $rose(lockFlag) |-> $past(cmpGood));  // R2

  AST_COUNT_BOUNDED: assert property (@(posedge clk) disable iff (rst)
    goodCnt < GCNT_W'(LOCK_LONG));  // R3

  AST_FALL_AFTER_BAD: assert property (@(posedge clk) disable iff (rst)
    $fell(lockFlag) |-> $past(cmpBad));  // R5

  AST_HOLD_NO_COMPARE: assert property (@(posedge clk) disable iff (rst)
    !cmpValid |=> (lockFlag == $past(lockFlag)));  // R6

  AST_SAT_DROPS: assert property (@(posedge clk) disable iff (rst)
    satEval |=> !lockFlag);  // R8

endmodule

bind pll_lock_qualifier lock_checker chk (
  .clk(clk), .rst(rst), .lockFlag(lockFlag),
  .cmpValid(cmpValid), .cmpGood(cmpGood), .cmpBad(cmpBad),
  .satEval(meterStb.evalSat), .goodCnt(goodCnt)
);

// File: tb/pll_lock_qualifier_test.sv
module pll_lock_qualifier_test;
  import lock_pkg::*;

  localparam int CLK_PERIOD = 10;
  localparam int TICK_W     = 8;
  localparam int SAT_TICKS  = (1 << TICK_W) - 1;

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic              refEdge = 1'b0;
  logic              fbEdge = 1'b0;
  logic              precisionSel = 1'b0;
  logic [TICK_W-1:0] tightThresh = TICK_W'(DEFAULT_TIGHT_TICKS);
  logic [TICK_W-1:0] looseThresh = TICK_W'(DEFAULT_LOOSE_TICKS);
  logic              lockFlag;

  int  nChecks = 0;
  int  nFails  = 0;
  bit  expLock = 1'b0;
  int  expGood = 0;
  bit  finished = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  pll_lock_qualifier #(.TICK_W(TICK_W)) uut (
    .clk(clk), .rst(rst), .refEdge(refEdge), .fbEdge(fbEdge),
    .precisionSel(precisionSel), .tightThresh(tightThresh),
    .looseThresh(looseThresh), .lockFlag(lockFlag)
  );

  task automatic check(input bit act, input bit exp, input string tag);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s: lockFlag=%0b expected %0b at %0t", tag, act, exp, $time);
    end
  endtask

  // Reference model built from the requirements
  task automatic model(input int err, input bit sat);
    int need = precisionSel ? 5 : 3;
    bit good = !sat && (err < int'(tightThresh));
    bit bad  = sat || (err > int'(looseThresh));
    if (expLock) begin
      expGood = 0;
      if (bad) expLock = 1'b0;
    end else if (good) begin
      expGood++;
      if (expGood >= need) begin expLock = 1'b1; expGood = 0; end
    end else begin
      expGood = 0;
    end
  endtask

  task automatic doReset();
    @(negedge clk);
    rst = 1'b1; refEdge = 1'b0; fbEdge = 1'b0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    expLock = 1'b0; expGood = 0;
    @(negedge clk);
  endtask

  // One comparison: leading edge, then the other edge gap ticks later
  task automatic compare(input bit refLeads, input int gap, input string tag);
    @(negedge clk);
    if (gap == 0) begin
      refEdge = 1'b1; fbEdge = 1'b1;
    end else if (refLeads) refEdge = 1'b1;
    else fbEdge = 1'b1;
    @(negedge clk);
    refEdge = 1'b0; fbEdge = 1'b0;
    if (gap > 0) begin
      repeat (gap - 1) @(negedge clk);
      if (refLeads) fbEdge = 1'b1; else refEdge = 1'b1;
      @(negedge clk);
      refEdge = 1'b0; fbEdge = 1'b0;
    end
    repeat (2) @(negedge clk);
    model(gap, 1'b0);
    check(lockFlag, expLock, tag);
  endtask

  task automatic testReset();
    doReset();
    check(lockFlag, 1'b0, "R1 reset state");
    precisionSel = 1'b0;
    compare(1, 1, "R1 run a");
    compare(1, 1, "R1 run b");
    doReset();
    compare(1, 1, "R1 after reset 1");
    compare(1, 1, "R1 after reset 2");
    compare(1, 1, "R1 after reset 3 locks");
  endtask

  task automatic testShort();
    doReset();
    precisionSel = 1'b0;
    compare(1, 2, "R2 good 1");
    compare(0, 1, "R2 good 2 no lock");
    compare(1, 2, "R2 good 3 locks");
    check(lockFlag, 1'b1, "R2 locked");
  endtask

  task automatic testLong();
    doReset();
    precisionSel = 1'b1;
    compare(1, 1, "R3 good 1");
    compare(0, 2, "R3 good 2");
    compare(1, 0, "R3 good 3");
    compare(0, 1, "R3 good 4 no lock");
    check(lockFlag, 1'b0, "R3 still low after four");
    compare(1, 2, "R3 good 5 locks");
    check(lockFlag, 1'b1, "R3 locked");
    precisionSel = 1'b0;
  endtask

  task automatic testTightEdge();
    doReset();
    compare(1, 2, "R4 good 1");
    compare(1, 2, "R4 good 2");
    compare(1, 3, "R4 error equal to tight restarts");
    compare(1, 1, "R4 regood 1");
    compare(1, 1, "R4 regood 2 no lock");
    check(lockFlag, 1'b0, "R4 restart held lock off");
    compare(1, 1, "R4 regood 3 locks");
    compare(0, 4, "R4 between thresholds while locked");
  endtask

  task automatic testLooseEdge();
    doReset();
    repeat (3) compare(1, 1, "R5 acquire");
    compare(1, 5, "R5 error equal to loose keeps lock");
    check(lockFlag, 1'b1, "R5 equal keeps");
    compare(0, 3, "R6 error at tight keeps lock");
    compare(1, 4, "R6 error inside band keeps lock");
    repeat (20) @(negedge clk);
    check(lockFlag, 1'b1, "R6 idle cycles keep lock");
    compare(1, 6, "R5 error above loose drops");
    check(lockFlag, 1'b0, "R5 dropped");
    compare(1, 1, "R5 relock needs full run 1");
    compare(1, 1, "R5 relock needs full run 2");
  endtask

  task automatic testDirection();
    doReset();
    compare(0, 0, "R7 coincident good 1");
    compare(1, 0, "R7 coincident good 2");
    compare(0, 2, "R7 feedback leads good 3");
    check(lockFlag, 1'b1, "R7 locked by coincident and fb-led");
    compare(0, 7, "R7 feedback leads by 7 drops");
    repeat (3) compare(1, 2, "R7 ref leads relock");
    compare(1, 7, "R7 ref leads by 7 drops");
  endtask

  task automatic testSaturate();
    doReset();
    repeat (3) compare(1, 1, "R8 acquire");
    @(negedge clk);
    refEdge = 1'b1;
    @(negedge clk);
    refEdge = 1'b0;
    repeat (200) @(negedge clk);
    check(lockFlag, 1'b1, "R8 lock held before saturation");
    repeat (SAT_TICKS) @(negedge clk);
    model(SAT_TICKS, 1'b1);
    check(lockFlag, 1'b0, "R8 saturation drops lock");
    repeat (3) compare(0, 1, "R8 recovers after saturation");
  endtask

  initial begin
    testReset();
    testShort();
    testLong();
    testTightEdge();
    testLooseEdge();
    testDirection();
    testSaturate();
    finished = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      nChecks++;
      nFails++;
      $display("FAIL watchdog: run did not complete, actual hung expected done");
      $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
      $finish;
    end
  end

endmodule